// File: doc/BRIEF.md
# SPI Mode Fault Status Controller

This block holds the error and status flag logic of an SPI port. It watches the slave-select level and raises a mode fault flag when that level contradicts the port's role. A master sees a fault whenever select is sampled low. A slave sees a fault when select returns high while the shifter still reports a transfer in progress. Receive-full, mode fault and overrun share one level interrupt request.

A master fault forces a shutdown. The port enable drops, the transmit-empty flag is set, a one-cycle pulse clears the shifter's state counter, and the pins go back to the general-purpose port logic. A slave fault only sets the flag. The role bit is never altered, so software can read which role faulted. The flag clears through a two-step sequence: a status read that sees the flag set, then a control write. The sequence only succeeds if no new fault arrives between the two steps.

There is no data stream at this block's edge. Every pin is a plain level or a single-cycle strobe, so there is no valid/ready handshake and no back-pressure.

Top module: `spi_fault_ctrl`

## Requirements
- R1: After reset `spi_en`, `fault_flag`, `cnt_clr`, `pin_own` and `irq` are 0, `tx_empty` is 1 and `master_sel` is 0.
- R2: With enable, master and fault-enable set, a low on `ss_n_pin` held from one falling clock edge sets `fault_flag` after the third following rising edge, and not before. The latency is two synchronizer stages plus one register.
- R3: A master fault clears `spi_en` and `pin_own`, sets `tx_empty`, and raises `cnt_clr` for exactly one cycle. All of these happen on the same edge that sets the flag.
- R4: With enable and fault-enable set in slave role, a rise of `ss_n_pin` while `xfer_busy` is 1 sets `fault_flag` with the same latency as R2. `spi_en` stays 1 and `cnt_clr` stays 0.
- R5: In slave role, a rise of `ss_n_pin` while `xfer_busy` is 0 does not set `fault_flag`.
- R6: While the fault-enable bit is 0, `fault_flag` is never set, in either role.
- R7: A fault never changes `master_sel`.
- R8: A `stat_rd` strobe while `fault_flag` is 1, followed by a `ctrl_wr` strobe, clears `fault_flag` on that write.
- R9: A `ctrl_wr` not preceded by an arming status read leaves `fault_flag` at 1.
- R10: A fault detected after the arming read and before the write cancels the sequence, and `fault_flag` stays 1 after the write.
- R11: `irq` equals (`rx_full` AND rx-interrupt enable) OR ((`fault_flag` OR `rx_overrun`) AND error-interrupt enable).
- R12: `data_wr` clears `tx_empty` and `tx_moved` sets it. A master fault takes priority over `data_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n_pin | input | 1 | Raw slave-select level, active low, asynchronous |
| xfer_busy | input | 1 | Shifter reports a transfer in progress |
| rx_full | input | 1 | Receive-full flag from the shifter |
| rx_overrun | input | 1 | Overrun flag from the shifter |
| stat_rd | input | 1 | Status register read strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| wr_en | input | 1 | Write data: port enable |
| wr_master | input | 1 | Write data: 1 = master role |
| wr_fault_en | input | 1 | Write data: mode fault detection enable |
| wr_rx_ie | input | 1 | Write data: receive interrupt enable |
| wr_err_ie | input | 1 | Write data: error interrupt enable |
| data_wr | input | 1 | Transmit data write strobe |
| tx_moved | input | 1 | Shifter took the transmit byte |
| spi_en | output | 1 | Port enable bit |
| master_sel | output | 1 | Role bit |
| tx_empty | output | 1 | Transmit-empty flag |
| fault_flag | output | 1 | Mode fault flag |
| cnt_clr | output | 1 | One-cycle state counter clear |
| pin_own | output | 1 | 1 = SPI drives the pins, 0 = port logic does |
| irq | output | 1 | Shared receive/error interrupt request |

## Verification
The hardest situation to reach from the ports is a fault that lands between the arming status read and the control write. The stimulus reaches it in slave role. It issues the read, then lowers and raises select around an asserted `xfer_busy`. It lets the synchronizer settle and only then issues the write, expecting the flag to survive. The interrupt equation is swept over every combination of its inputs, with the flag both clear and set.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
  typedef struct packed {
    logic en;
    logic master;
    logic fault_en;
    logic rx_ie;
    logic err_ie;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{en: 1'b0, master: 1'b0, fault_en: 1'b0,
                                 rx_ie: 1'b0, err_ie: 1'b0};
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/spi_fault_sync.sv
module spi_fault_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = STAGES - 1;
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[LAST-1:0], d};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/spi_fault_detect.sv
module spi_fault_detect
  import spi_fault_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ss_lvl,
  input  logic  busy,
  input  ctrl_t ctrl,
  output logic  master_evt,
  output logic  slave_evt
);
  logic ss_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_prev <= 1'b1;
    else        ss_prev <= ss_lvl;
  end

  // master: any sampled low select is a contention with another master
  assign master_evt = ctrl.en & ctrl.master & ctrl.fault_en & ~ss_lvl;
  // slave: select released while a transfer is still running
  assign slave_evt  = ctrl.en & ~ctrl.master & ctrl.fault_en & busy &
                      ss_lvl & ~ss_prev;

  // R3/R4: the two roles are exclusive
  p_one_role_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({master_evt, slave_evt}) <= 1);
endmodule

// File: rtl/spi_fault_flags.sv
module spi_fault_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_evt,
  input  logic master_evt,
  input  logic fault_en,
  input  logic stat_rd,
  input  logic ctrl_wr,
  input  logic data_wr,
  input  logic tx_moved,
  output logic modf,
  output logic txe,
  output logic cnt_clr
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modf  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (fault_evt)            modf <= 1'b1;
      else if (ctrl_wr && armed) modf <= 1'b0;

      if (fault_evt || ctrl_wr)  armed <= 1'b0;
      else if (stat_rd && modf)  armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe     <= 1'b1;
      cnt_clr <= 1'b0;
    end else begin
      cnt_clr <= master_evt;
      if (master_evt)    txe <= 1'b1;
      else if (data_wr)  txe <= 1'b0;
      else if (tx_moved) txe <= 1'b1;
    end
  end

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!modf && !fault_en) |=> !modf);
  p_clear_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(modf) |-> $past(ctrl_wr));
  p_cnt_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !cnt_clr);
  p_txe_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    master_evt |=> txe);
endmodule

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl
  import spi_fault_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_n_pin,
  input  logic xfer_busy,
  input  logic rx_full,
  input  logic rx_overrun,
  input  logic stat_rd,
  input  logic ctrl_wr,
  input  logic wr_en,
  input  logic wr_master,
  input  logic wr_fault_en,
  input  logic wr_rx_ie,
  input  logic wr_err_ie,
  input  logic data_wr,
  input  logic tx_moved,
  output logic spi_en,
  output logic master_sel,
  output logic tx_empty,
  output logic fault_flag,
  output logic cnt_clr,
  output logic pin_own,
  output logic irq
);
  ctrl_t ctrl_q;
  logic  ss_lvl, master_evt, slave_evt, fault_evt;

  spi_fault_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ss_n_pin), .q(ss_lvl));

  spi_fault_detect u_det (
    .clk(clk), .rst_n(rst_n), .ss_lvl(ss_lvl), .busy(xfer_busy),
    .ctrl(ctrl_q), .master_evt(master_evt), .slave_evt(slave_evt));

  assign fault_evt = master_evt | slave_evt;

  spi_fault_flags u_flags (
    .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .master_evt(master_evt),
    .fault_en(ctrl_q.fault_en), .stat_rd(stat_rd), .ctrl_wr(ctrl_wr),
    .data_wr(data_wr), .tx_moved(tx_moved), .modf(fault_flag),
    .txe(tx_empty), .cnt_clr(cnt_clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else begin
      if (ctrl_wr) ctrl_q <= '{en: wr_en, master: wr_master,
                               fault_en: wr_fault_en, rx_ie: wr_rx_ie,
                               err_ie: wr_err_ie};
      if (master_evt) ctrl_q.en <= 1'b0;
    end
  end

  assign spi_en     = ctrl_q.en;
  assign master_sel = ctrl_q.master;
  assign pin_own    = ctrl_q.en;
  assign irq        = (rx_full & ctrl_q.rx_ie) |
                      ((fault_flag | rx_overrun) & ctrl_q.err_ie);

  p_master_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    master_evt |=> !spi_en && !pin_own);
  p_slave_keeps_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_evt && !ctrl_wr) |=> spi_en);
  p_role_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt && !ctrl_wr) |=> $stable(master_sel));
endmodule

// File: tb/spi_fault_ctrl_test.sv
module spi_fault_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ss_n_pin = 1'b1, xfer_busy = 1'b0, rx_full = 1'b0, rx_overrun = 1'b0;
  logic stat_rd = 1'b0, ctrl_wr = 1'b0, data_wr = 1'b0, tx_moved = 1'b0;
  logic wr_en = 1'b0, wr_master = 1'b0, wr_fault_en = 1'b0;
  logic wr_rx_ie = 1'b0, wr_err_ie = 1'b0;
  logic spi_en, master_sel, tx_empty, fault_flag, cnt_clr, pin_own, irq;
  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  spi_fault_ctrl uut (.*);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic e, m, f, ri, ei);
    ctrl_wr = 1'b1; wr_en = e; wr_master = m; wr_fault_en = f;
    wr_rx_ie = ri; wr_err_ie = ei;
    step(1);
    ctrl_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1; step(1); stat_rd = 1'b0;
  endtask

  task automatic slave_toggle(input logic busy);
    ss_n_pin = 1'b0; step(4);
    xfer_busy = busy; ss_n_pin = 1'b1; step(4);
    xfer_busy = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(2); rst_n = 1'b1; step(1);
    // R1 reset values
    chk("R1 spi_en", spi_en, 1'b0);
    chk("R1 tx_empty", tx_empty, 1'b1);
    chk("R1 fault_flag", fault_flag, 1'b0);
    chk("R1 cnt_clr", cnt_clr, 1'b0);
    chk("R1 pin_own", pin_own, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 master_sel", master_sel, 1'b0);

    // R12 data write clears tx_empty
    data_wr = 1'b1; step(1); data_wr = 1'b0;
    chk("R12 data_wr clears", tx_empty, 1'b0);

    // R2 / R3 master fault
    wr_ctrl(1, 1, 1, 0, 0);
    chk("R3 pin_own on", pin_own, 1'b1);
    ss_n_pin = 1'b0;
    step(2);
    chk("R2 not yet", fault_flag, 1'b0);
    step(1);
    chk("R2 flag set", fault_flag, 1'b1);
    chk("R3 cnt_clr pulse", cnt_clr, 1'b1);
    chk("R3 spi_en off", spi_en, 1'b0);
    chk("R3 pin_own off", pin_own, 1'b0);
    chk("R3 tx_empty set", tx_empty, 1'b1);
    chk("R7 role kept master", master_sel, 1'b1);
    step(1);
    chk("R3 cnt_clr one cycle", cnt_clr, 1'b0);

    // R9 write without arming read
    wr_ctrl(0, 1, 1, 0, 0);
    chk("R9 flag stays", fault_flag, 1'b1);
    // R8 read then write
    pulse_rd();
    wr_ctrl(0, 1, 1, 0, 0);
    chk("R8 flag cleared", fault_flag, 1'b0);
    ss_n_pin = 1'b1; step(4);

    // R6 fault-enable low, master
    wr_ctrl(1, 1, 0, 0, 0);
    ss_n_pin = 1'b0; step(5);
    chk("R6 master no flag", fault_flag, 1'b0);
    chk("R6 master stays enabled", spi_en, 1'b1);
    ss_n_pin = 1'b1; step(4);
    // R6 fault-enable low, slave
    wr_ctrl(1, 0, 0, 0, 0);
    slave_toggle(1'b1);
    chk("R6 slave no flag", fault_flag, 1'b0);

    // R5 slave, no transfer running
    wr_ctrl(1, 0, 1, 0, 0);
    slave_toggle(1'b0);
    chk("R5 idle release no flag", fault_flag, 1'b0);

    // R4 slave fault
    ss_n_pin = 1'b0; step(4);
    xfer_busy = 1'b1; ss_n_pin = 1'b1;
    step(2);
    chk("R4 not yet", fault_flag, 1'b0);
    step(1);
    chk("R4 flag set", fault_flag, 1'b1);
    chk("R4 spi_en kept", spi_en, 1'b1);
    chk("R4 no cnt_clr", cnt_clr, 1'b0);
    chk("R7 role kept slave", master_sel, 1'b0);
    xfer_busy = 1'b0; step(2);

    // R10 fault between read and write
    pulse_rd();
    slave_toggle(1'b1);
    wr_ctrl(1, 0, 1, 0, 0);
    chk("R10 flag survives", fault_flag, 1'b1);
    pulse_rd();
    wr_ctrl(1, 0, 1, 0, 0);
    chk("R8 slave clear", fault_flag, 1'b0);

    // R12 tx_moved sets, data_wr clears
    data_wr = 1'b1; step(1); data_wr = 1'b0;
    chk("R12 cleared", tx_empty, 1'b0);
    tx_moved = 1'b1; step(1); tx_moved = 1'b0;
    chk("R12 tx_moved sets", tx_empty, 1'b1);

    // R11 sweep with flag clear
    for (int v = 0; v < 16; v++) begin
      logic rf, ov, ri, ei;
      {rf, ov, ri, ei} = 4'(v);
      rx_full = rf; rx_overrun = ov;
      wr_ctrl(1, 0, 1, ri, ei);
      chk("R11 sweep flag clear", irq, (rf & ri) | (ov & ei));
    end
    rx_full = 1'b0; rx_overrun = 1'b0;
    wr_ctrl(1, 0, 1, 0, 0);
    slave_toggle(1'b1);
    chk("R4 flag for sweep", fault_flag, 1'b1);
    for (int v = 0; v < 8; v++) begin
      logic rf, ri, ei;
      {rf, ri, ei} = 3'(v);
      rx_full = rf;
      wr_ctrl(1, 0, 1, ri, ei);
      chk("R11 sweep flag set", irq, (rf & ri) | ei);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule